// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer with a register port. A 31-bit counter advances on a slow tick enable while either of two enable bits is set. Software chooses a power-of-two prescale (0 to 15 positions). The prescaled view of the counter, cut down to 16 bits, is compared against a 16-bit threshold. When the view reaches the threshold, a sticky pending flag is set. That flag drives the interrupt level. A one-cycle reset request and an automatic counter clear can also follow the match, each chosen by its own option bit.

Software may change the configuration, the counter, the threshold or the feed register only after it writes a key word to the key register. One such write then goes through and closes the lock again, even when it has no other effect. Software keeps the timer alive by writing a magic word to the feed register. Word offsets that the block does not decode read as zero.

Top module: `wdk_keylock`

## Requirements
- R1: Word offsets are: config 0x00, raw count 0x08, scaled count 0x10, feed 0x18, key 0x1C, compare 0x20. Reading feed returns 0. Any other offset reads 0. Read data is valid in the same cycle that bus_sel is high.
- R2: Config bits are: scale [3:0], reset-enable 8, zero-on-match 9, run-always 12, run-while-awake 13, pending 28. Reserved bits read as 0.
- R3: At each clock with tick high and bit 12 or bit 13 set, the counter increments by one. It wraps from 0x7FFFFFFF to 0. With both bits clear, the counter holds its value.
- R4: The scaled count reads as bits [15:0] of (count >> scale).
- R5: While scaled count >= compare, pending is set at the next clock. With reset-enable set, rst_req is high for exactly one cycle, in the cycle after the condition first becomes true. With zero-on-match set, the counter is cleared at the next clock.
- R6: Writing 0x0051F15E to the key register opens the lock, and key reads back 1. A key write with any other data leaves the lock unchanged. Writes to config, count, feed or compare are ignored while the lock is closed, and each accepted one closes it.
- R7: An accepted feed write clears the counter only when its data is 0x0D09F00D. With any other data the counter is kept, but the lock still closes.
- R8: An accepted count write loads data bits [30:0]. Writes to the scaled-count offset never change anything.
- R9: After reset: config reads 0, compare reads 0xBEEF, count reads 0, key reads 0, irq and rst_req are 0.
- R10: irq equals the pending bit. Pending stays set until a config write with bit 28 at 0 is made while the match condition is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow count enable |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Pending interrupt level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The scale is swept through all 16 values over three counter patterns. These patterns show whether the shift, the 16-bit cut and the read path line up. Lock tests try a wrong key, a locked write, a second write after one accepted write, and a feed with the wrong word. Together they separate "ignored" from "consumed". Compare tests count ticks up to the threshold and check the exact cycle of pending and of the reset pulse. They also try to clear pending while the match still holds, and run zero-on-match with the reset option off.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   // register word offsets (byte addresses)
   localparam int unsigned OFS_CFG   = 'h00;
   localparam int unsigned OFS_COUNT = 'h08;
   localparam int unsigned OFS_SCALE = 'h10;
   localparam int unsigned OFS_FEED  = 'h18;
   localparam int unsigned OFS_KEY   = 'h1C;
   localparam int unsigned OFS_CMP   = 'h20;

   // config bit positions
   localparam int unsigned CB_RSTEN  = 8;
   localparam int unsigned CB_ZERO   = 9;
   localparam int unsigned CB_RUNALL = 12;
   localparam int unsigned CB_RUNAWK = 13;
   localparam int unsigned CB_PEND   = 28;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_CFG, SEL_COUNT, SEL_SCALE, SEL_FEED, SEL_KEY, SEL_CMP
   } wdk_sel_e;
endpackage

// File: rtl/wdk_counter.sv
module wdk_counter #(
   parameter int unsigned CNT_W   = 31,
   parameter int unsigned CMP_W   = 16,
   parameter int unsigned SCALE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               run,
   input  logic               zero_on_match,
   input  logic [SCALE_W-1:0] scale,
   input  logic [CMP_W-1:0]   cmp_val,
   input  logic               load,
   input  logic [CNT_W-1:0]   load_val,
   input  logic               feed_clr,
   output logic [CNT_W-1:0]   cnt_q,
   output logic [CMP_W-1:0]   scaled,
   output logic               match
);
   localparam int unsigned MAX_SHIFT = (1 << SCALE_W) - 1;

   generate
      if (CMP_W > CNT_W) begin : g_bad_cmp
         $error("compare width exceeds counter width");
      end
      if (MAX_SHIFT >= CNT_W) begin : g_bad_scale
         $error("scale range shifts the whole counter out");
      end
   endgenerate

   logic [CNT_W-1:0] shifted;

   always_comb begin
      shifted = cnt_q >> scale;
      scaled  = shifted[CMP_W-1:0];
      match   = (scaled >= cmp_val);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (load)                        cnt_q <= load_val;
      else if (feed_clr)                    cnt_q <= '0;
      else if (match && zero_on_match)      cnt_q <= '0;
      else if (tick && run)                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 31,
   parameter int unsigned CMP_W    = 16,
   parameter int unsigned SCALE_W  = 4,
   parameter logic [31:0] KEY_VAL  = 32'h0051_F15E,
   parameter logic [31:0] FEED_VAL = 32'h0D09_F00D,
   parameter logic [CMP_W-1:0] CMP_RST = 16'hBEEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [CNT_W-1:0]   cnt_q,
   input  logic [CMP_W-1:0]   scaled,
   input  logic               match,
   output logic [SCALE_W-1:0] scale,
   output logic               run,
   output logic               zero_on_match,
   output logic [CMP_W-1:0]   cmp_q,
   output logic               cnt_load,
   output logic               feed_clr,
   output logic               key_open,
   output logic               irq,
   output logic               rst_req
);
   wdk_sel_e sel;
   logic wr, prot, accept, key_hit;
   logic rsten_q, zero_q, runall_q, runawk_q, pend_q, match_q;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_CFG))   sel = SEL_CFG;
      else if (bus_addr == ADDR_W'(OFS_COUNT)) sel = SEL_COUNT;
      else if (bus_addr == ADDR_W'(OFS_SCALE)) sel = SEL_SCALE;
      else if (bus_addr == ADDR_W'(OFS_FEED))  sel = SEL_FEED;
      else if (bus_addr == ADDR_W'(OFS_KEY))   sel = SEL_KEY;
      else if (bus_addr == ADDR_W'(OFS_CMP))   sel = SEL_CMP;
      else                                     sel = SEL_NONE;
      wr      = bus_sel && bus_we;
      prot    = (sel == SEL_CFG) || (sel == SEL_COUNT) ||
                (sel == SEL_FEED) || (sel == SEL_CMP);
      accept  = wr && prot && key_open;
      key_hit = wr && (sel == SEL_KEY) && (bus_wdata == KEY_VAL);
      cnt_load = accept && (sel == SEL_COUNT);
      feed_clr = accept && (sel == SEL_FEED) && (bus_wdata == FEED_VAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_open <= 1'b0;
         scale    <= '0;
         rsten_q  <= 1'b0;
         zero_q   <= 1'b0;
         runall_q <= 1'b0;
         runawk_q <= 1'b0;
         pend_q   <= 1'b0;
         cmp_q    <= CMP_RST;
         match_q  <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         if (key_hit)     key_open <= 1'b1;
         else if (accept) key_open <= 1'b0;
         if (accept && sel == SEL_CFG) begin
            scale    <= bus_wdata[SCALE_W-1:0];
            rsten_q  <= bus_wdata[CB_RSTEN];
            zero_q   <= bus_wdata[CB_ZERO];
            runall_q <= bus_wdata[CB_RUNALL];
            runawk_q <= bus_wdata[CB_RUNAWK];
            pend_q   <= bus_wdata[CB_PEND] | match;
         end else begin
            pend_q   <= pend_q | match;
         end
         if (accept && sel == SEL_CMP) cmp_q <= bus_wdata[CMP_W-1:0];
         match_q <= match;
         rst_req <= match && !match_q && rsten_q;
      end
   end

   always_comb begin
      run           = runall_q || runawk_q;
      zero_on_match = zero_q;
      irq           = pend_q;
      bus_rdata     = '0;
      if (bus_sel) begin
         unique case (sel)
            SEL_CFG: begin
               bus_rdata[SCALE_W-1:0] = scale;
               bus_rdata[CB_RSTEN]    = rsten_q;
               bus_rdata[CB_ZERO]     = zero_q;
               bus_rdata[CB_RUNALL]   = runall_q;
               bus_rdata[CB_RUNAWK]   = runawk_q;
               bus_rdata[CB_PEND]     = pend_q;
            end
            SEL_COUNT: bus_rdata = 32'(cnt_q);
            SEL_SCALE: bus_rdata = 32'(scaled);
            SEL_KEY:   bus_rdata = 32'(key_open);
            SEL_CMP:   bus_rdata = 32'(cmp_q);
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/wdk_keylock.sv
module wdk_keylock #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 31,
   parameter int unsigned CMP_W    = 16,
   parameter int unsigned SCALE_W  = 4,
   parameter logic [31:0] KEY_VAL  = 32'h0051_F15E,
   parameter logic [31:0] FEED_VAL = 32'h0D09_F00D,
   parameter logic [CMP_W-1:0] CMP_RST = 16'hBEEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              rst_req
);
   generate
      if (CNT_W >= 32) begin : g_bad_cnt
         $error("counter must be narrower than the data word");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("address too narrow for the register window");
      end
   endgenerate

   logic [CNT_W-1:0]   cnt_q;
   logic [CMP_W-1:0]   scaled, cmp_q;
   logic [SCALE_W-1:0] scale;
   logic match, run, zero_on_match, cnt_load, feed_clr, key_open;

   wdk_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W),
      .KEY_VAL(KEY_VAL), .FEED_VAL(FEED_VAL), .CMP_RST(CMP_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_q(cnt_q), .scaled(scaled), .match(match),
      .scale(scale), .run(run), .zero_on_match(zero_on_match),
      .cmp_q(cmp_q), .cnt_load(cnt_load), .feed_clr(feed_clr),
      .key_open(key_open), .irq(irq), .rst_req(rst_req)
   );

   wdk_counter #(
      .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
      .zero_on_match(zero_on_match), .scale(scale), .cmp_val(cmp_q),
      .load(cnt_load), .load_val(bus_wdata[CNT_W-1:0]), .feed_clr(feed_clr),
      .cnt_q(cnt_q), .scaled(scaled), .match(match)
   );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              key_open,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              match,
   input logic              irq,
   input logic              rst_req
);
   logic wr, prot_wr, cfg_wr;
   always_comb begin
      wr      = bus_sel && bus_we;
      cfg_wr  = wr && (bus_addr == ADDR_W'('h00));
      prot_wr = wr && ((bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h08)) ||
                       (bus_addr == ADDR_W'('h18)) || (bus_addr == ADDR_W'('h20)));
   end

   a_r6_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr && key_open) |=> !key_open);

   a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r5_pulse_with_pending: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> irq);

   a_r10_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cfg_wr) |=> irq);

   a_r3_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !match) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr && !match) |=> $stable(cnt_q));
endmodule

bind wdk_keylock wdk_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .key_open(key_open), .cnt_q(cnt_q), .match(match),
   .irq(irq), .rst_req(rst_req)
);

// File: tb/wdk_keylock_test.sv
module wdk_keylock_test;
   localparam logic [31:0] KEY  = 32'h0051_F15E;
   localparam logic [31:0] FEED = 32'h0D09_F00D;
   localparam logic [7:0] A_CFG = 8'h00, A_CNT = 8'h08, A_SCL = 8'h10,
                          A_FEED = 8'h18, A_KEY = 8'h1C, A_CMP = 8'h20;
   localparam logic [31:0] C_RSTEN = 32'h100, C_ZERO = 32'h200,
                           C_RUNALL = 32'h1000, C_RUNAWK = 32'h2000;

   logic clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_we = 0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic irq, rst_req;
   int tests = 0, fails = 0, pulses = 0;
   logic [31:0] rv;
   logic [31:0] pat [3];

   wdk_keylock uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .rst_req(rst_req)
   );

   always #2 clk = ~clk;
   always @(negedge clk) if (rst_req) pulses++;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic pw(input logic [7:0] a, input logic [31:0] d);
      wr(A_KEY, KEY);
      wr(a, d);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset state
      rd(A_CFG, rv); chk("R9 cfg", rv, 0);
      rd(A_CMP, rv); chk("R9 cmp", rv, 32'hBEEF);
      rd(A_CNT, rv); chk("R9 count", rv, 0);
      rd(A_KEY, rv); chk("R9 key", rv, 0);
      chk("R9 irq", {31'b0, irq}, 0);
      chk("R9 rst_req", {31'b0, rst_req}, 0);
      // R1 feed and unmapped reads
      rd(A_FEED, rv); chk("R1 feed reads 0", rv, 0);
      rd(8'h40, rv);  chk("R1 unmapped 0x40", rv, 0);
      rd(8'h04, rv);  chk("R1 unmapped 0x04", rv, 0);
      // R6 lock behaviour
      wr(A_CMP, 32'h1234); rd(A_CMP, rv); chk("R6 locked cmp write", rv, 32'hBEEF);
      wr(A_KEY, 32'hDEAD); rd(A_KEY, rv); chk("R6 wrong key", rv, 0);
      wr(A_KEY, KEY);      rd(A_KEY, rv); chk("R6 key opens", rv, 1);
      wr(A_CMP, 32'h1234); rd(A_CMP, rv); chk("R6 accepted cmp", rv, 32'h1234);
      rd(A_KEY, rv); chk("R6 lock consumed", rv, 0);
      wr(A_CMP, 32'h5555); rd(A_CMP, rv); chk("R6 second write ignored", rv, 32'h1234);
      // R8 count mask and scaled write ignored
      pw(A_CNT, 32'hFFFF_FFFF); rd(A_CNT, rv); chk("R8 count masked", rv, 32'h7FFF_FFFF);
      pw(A_CNT, 32'h0000_0123);
      wr(A_KEY, KEY); wr(A_SCL, 32'h0000_0777);
      rd(A_CNT, rv); chk("R8 scaled write ignored", rv, 32'h123);
      wr(A_CNT, 32'h0); // consumes the still-open lock
      // R2 config fields, reserved bits zero
      pw(A_CMP, 32'hFFFF);
      pw(A_CFG, 32'hEFFF_FFFF); rd(A_CFG, rv); chk("R2 config fields", rv, 32'h0000_330F);
      // R4 scale sweep
      pat[0] = 32'h1234_5678; pat[1] = 32'h2AAA_AAAA; pat[2] = 32'h00C0_FFEE;
      for (int p = 0; p < 3; p++) begin
         pw(A_CNT, pat[p]);
         for (int s = 0; s < 16; s++) begin
            pw(A_CFG, C_RUNALL | 32'(s));
            rd(A_SCL, rv);
            chk($sformatf("R4 scaled p%0d s%0d", p, s), rv, (pat[p] >> s) & 32'hFFFF);
         end
      end
      // R3 counting, each enable, disabled hold, wrap
      pw(A_CFG, C_RUNALL); pw(A_CNT, 0);
      ticks(7); rd(A_CNT, rv); chk("R3 run-always count", rv, 7);
      pw(A_CFG, C_RUNAWK);
      ticks(3); rd(A_CNT, rv); chk("R3 run-awake count", rv, 10);
      pw(A_CFG, 0);
      ticks(4); rd(A_CNT, rv); chk("R3 disabled hold", rv, 10);
      pw(A_CFG, C_RUNALL); pw(A_CNT, 32'h7FFF_FFFF);
      ticks(1); rd(A_CNT, rv); chk("R3 wrap", rv, 0);
      // R7 feed
      pw(A_CNT, 32'h100);
      pw(A_FEED, 32'h1234_5678); rd(A_CNT, rv); chk("R7 wrong feed keeps", rv, 32'h100);
      rd(A_KEY, rv); chk("R7 wrong feed closes lock", rv, 0);
      wr(A_FEED, FEED); rd(A_CNT, rv); chk("R7 locked feed ignored", rv, 32'h100);
      pw(A_FEED, FEED); rd(A_CNT, rv); chk("R7 magic feed clears", rv, 0);
      // R5 / R10 compare with reset request
      pw(A_CNT, 0); pw(A_CMP, 5);
      pw(A_CFG, C_RSTEN | C_RUNALL | 32'd1);
      chk("R10 pending cleared", {31'b0, irq}, 0);
      pulses = 0;
      ticks(9);
      chk("R5 below threshold irq", {31'b0, irq}, 0);
      ticks(1);
      #1 chk("R5 match cycle irq not yet", {31'b0, irq}, 0);
      chk("R5 match cycle no pulse yet", {31'b0, rst_req}, 0);
      @(negedge clk); #1;
      chk("R5 pending set", {31'b0, irq}, 1);
      chk("R5 reset pulse", {31'b0, rst_req}, 1);
      @(negedge clk); #1;
      chk("R5 pulse one cycle", {31'b0, rst_req}, 0);
      repeat (5) @(negedge clk);
      chk("R5 single pulse count", 32'(pulses), 1);
      pw(A_CFG, C_RUNALL | 32'd1);
      chk("R10 clear ignored during match", {31'b0, irq}, 1);
      pw(A_CNT, 0);
      chk("R10 pending sticky", {31'b0, irq}, 1);
      pw(A_CFG, C_RUNALL | 32'd1);
      chk("R10 pending cleared by write", {31'b0, irq}, 0);
      // R5 zero-on-match without reset request
      pw(A_CMP, 3); pw(A_CFG, C_ZERO | C_RUNALL);
      ticks(3);
      @(negedge clk);
      rd(A_CNT, rv); chk("R5 zero on match", rv, 0);
      chk("R5 zero-match pending", {31'b0, irq}, 1);
      chk("R5 no pulse without enable", 32'(pulses), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule